// File: doc/BRIEF.md
# Streamed FFT Frame Header Parser with Status Insertion

This block stands at the edge of a run-time configurable FFT path. Each frame on the input stream opens with a 256-bit header. With 16-bit I/Q components the header is eight complex samples, and the payload follows it. The block takes in the whole header and decodes two things from it: the transform direction and the requested transform length, given as a power of two. It then checks that length against a legal window. The header goes back out on the output stream with its status slot overwritten by the result of that check. The decoded settings are handed to the downstream engine as a single-cycle configuration strobe.

A frame with a legal length has its payload forwarded sample for sample. A frame with an illegal length has its full maximum-length payload taken in and dropped, so the next header is still found at the correct place in the input stream. The output header is emitted from internal storage. While that happens the input side is held off, so no incoming sample is lost.

Top module: `frame_hdr_parser`

## Requirements
- R1: While reset is held, in_ready_o is 1, out_valid_o is 0 and cfg_valid_o is 0.
- R2: The first eight input samples of a frame are taken as the header, and the eight-sample output header follows them. in_ready_o stays low for the whole time that output header is being emitted, and no input sample is dropped.
- R3: The high half (real part, bits 31:16) of header sample 0 selects the direction. A value of 0 drives cfg_fwd_o to 0 (inverse). Any non-zero value drives it to 1 (forward).
- R4: The real part of header sample 1 is the log2 transform length. All 16 bits of it are latched and presented on cfg_log2_o.
- R5: A length is legal when its log2 value lies between MIN_LOG2 and MAX_LOG2 inclusive, compared over all 16 bits. In the output header, the real part of sample 3 is 0 for a legal length and 1 for an illegal one. The imaginary part of sample 3 and every other header sample are copied unchanged. Whatever arrives in the status slot on input has no effect.
- R6: cfg_valid_o pulses for exactly one cycle after the last output header sample and before any payload sample moves. In that cycle in_ready_o and out_valid_o are both 0.
- R7: A legal frame forwards exactly 2^log2 payload samples unchanged. After them the block expects the next header.
- R8: An illegal frame consumes 2^MAX_LOG2 input samples and presents none of them. After them the block expects the next header.
- R9: While out_valid_o is high and out_ready_i is low, out_data_o holds its value. During the payload, in_ready_o follows out_ready_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample accepted when high with valid |
| in_data_i | input | 32 | Input sample, real in 31:16, imaginary in 15:0 |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Downstream can take a sample |
| out_data_o | output | 32 | Output sample, same packing as input |
| cfg_valid_o | output | 1 | One-cycle strobe with the decoded frame settings |
| cfg_fwd_o | output | 1 | 1 for forward transform, 0 for inverse |
| cfg_log2_o | output | 16 | Requested log2 transform length |
| cfg_legal_o | output | 1 | 1 when the requested length is in range |

## Verification
The hardest condition to reach is input and output pressure arriving at the same time around a frame boundary. That means a header emission stalled by out_ready_i while the source is already offering the next payload, or a dropped frame running straight into the next header. The stimulus reaches these cases with a back-to-back stream of frames whose lengths sweep below, across and above the legal window, plus one length that is legal only in its low bits. Valid and ready are each throttled on co-prime periods, so stalls land on every phase of every frame. The bench checks that each configuration strobe arrives at the exact input and output positions the frame layout predicts.

// File: rtl/fhp_pkg.sv
package fhp_pkg;
  localparam int HDR_BITS = 256;

  typedef enum logic [2:0] {
    ST_HDR_IN,
    ST_HDR_OUT,
    ST_CFG,
    ST_BODY,
    ST_DROP
  } fhp_state_e;
endpackage

// File: rtl/fhp_hdr_buf.sv
module fhp_hdr_buf #(
  parameter int DATA_W   = 16,
  parameter int HDR_LEN  = 8,
  parameter int MIN_LOG2 = 4,
  parameter int MAX_LOG2 = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [$clog2(HDR_LEN)-1:0] idx_i,
  input  logic [2*DATA_W-1:0]        wr_data_i,
  input  logic                       latch_i,
  output logic [2*DATA_W-1:0]        rd_data_o,
  output logic                       fwd_o,
  output logic [DATA_W-1:0]          log2_o,
  output logic                       legal_o
);
  localparam int SMP_W     = 2 * DATA_W;
  localparam int DIR_SLOT  = 0;
  localparam int SIZE_SLOT = 1;
  localparam int STAT_SLOT = 3;

  logic [SMP_W-1:0]  mem_q [HDR_LEN];
  logic [DATA_W-1:0] size_fld;
  logic [DATA_W-1:0] dir_fld;
  logic              size_ok;

  assign dir_fld  = mem_q[DIR_SLOT][SMP_W-1 -: DATA_W];
  assign size_fld = mem_q[SIZE_SLOT][SMP_W-1 -: DATA_W];
  assign size_ok  = (size_fld >= DATA_W'(MIN_LOG2)) && (size_fld <= DATA_W'(MAX_LOG2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < HDR_LEN; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[idx_i] <= wr_data_i;
    end
  end

  // slots 0 and 1 are already stored when the last header word arrives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_o   <= 1'b0;
      log2_o  <= '0;
      legal_o <= 1'b0;
    end else if (latch_i) begin
      fwd_o   <= |dir_fld;
      log2_o  <= size_fld;
      legal_o <= size_ok;
    end
  end

  always_comb begin
    rd_data_o = mem_q[idx_i];
    if (idx_i == $clog2(HDR_LEN)'(STAT_SLOT))
      rd_data_o[SMP_W-1 -: DATA_W] = {{(DATA_W-1){1'b0}}, ~legal_o};
  end
endmodule

// File: rtl/fhp_ctrl.sv
module fhp_ctrl
  import fhp_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int HDR_LEN  = 8,
  parameter int MAX_LOG2 = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic                       out_ready_i,
  input  logic                       legal_i,
  input  logic [DATA_W-1:0]          log2_i,
  output logic [$clog2(HDR_LEN)-1:0] idx_o,
  output logic                       hdr_wr_o,
  output logic                       latch_o,
  output logic                       sel_hdr_o,
  output logic                       in_ready_o,
  output logic                       out_valid_o,
  output logic                       cfg_valid_o,
  output logic                       drop_o
);
  localparam int IDX_W = $clog2(HDR_LEN);
  localparam int CNT_W = MAX_LOG2;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_LEN - 1);

  fhp_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] body_last;

  assign body_last = CNT_W'((32'd1 << log2_i) - 32'd1);
  assign idx_o     = idx_q;
  assign drop_o    = (state_q == ST_DROP);

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    cnt_d       = cnt_q;
    hdr_wr_o    = 1'b0;
    latch_o     = 1'b0;
    sel_hdr_o   = 1'b0;
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    cfg_valid_o = 1'b0;
    unique case (state_q)
      ST_HDR_IN: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          hdr_wr_o = 1'b1;
          if (idx_q == IDX_LAST) begin
            idx_d   = '0;
            latch_o = 1'b1;
            state_d = ST_HDR_OUT;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_HDR_OUT: begin
        sel_hdr_o   = 1'b1;
        out_valid_o = 1'b1;
        if (out_ready_i) begin
          if (idx_q == IDX_LAST) begin
            idx_d   = '0;
            state_d = ST_CFG;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_CFG: begin
        cfg_valid_o = 1'b1;
        cnt_d       = '0;
        state_d     = legal_i ? ST_BODY : ST_DROP;
      end
      ST_BODY: begin
        in_ready_o  = out_ready_i;
        out_valid_o = in_valid_i;
        if (in_valid_i && out_ready_i) begin
          if (cnt_q == body_last) state_d = ST_HDR_IN;
          else                    cnt_d   = cnt_q + 1'b1;
        end
      end
      ST_DROP: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          if (&cnt_q) state_d = ST_HDR_IN;
          else        cnt_d   = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_HDR_IN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR_IN;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/frame_hdr_parser.sv
module frame_hdr_parser
  import fhp_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MIN_LOG2 = 4,
  parameter int MAX_LOG2 = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [2*DATA_W-1:0] in_data_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [2*DATA_W-1:0] out_data_o,
  output logic                cfg_valid_o,
  output logic                cfg_fwd_o,
  output logic [DATA_W-1:0]   cfg_log2_o,
  output logic                cfg_legal_o
);
  localparam int SMP_W   = 2 * DATA_W;
  localparam int HDR_LEN = HDR_BITS / SMP_W;
  localparam int IDX_W   = $clog2(HDR_LEN);

  logic [IDX_W-1:0] hdr_idx;
  logic             hdr_wr;
  logic             hdr_latch;
  logic             hdr_emit;
  logic             drop_act;
  logic [SMP_W-1:0] hdr_rd;

  fhp_hdr_buf #(
    .DATA_W  (DATA_W),
    .HDR_LEN (HDR_LEN),
    .MIN_LOG2(MIN_LOG2),
    .MAX_LOG2(MAX_LOG2)
  ) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (hdr_wr),
    .idx_i    (hdr_idx),
    .wr_data_i(in_data_i),
    .latch_i  (hdr_latch),
    .rd_data_o(hdr_rd),
    .fwd_o    (cfg_fwd_o),
    .log2_o   (cfg_log2_o),
    .legal_o  (cfg_legal_o)
  );

  fhp_ctrl #(
    .DATA_W  (DATA_W),
    .HDR_LEN (HDR_LEN),
    .MAX_LOG2(MAX_LOG2)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .out_ready_i(out_ready_i),
    .legal_i    (cfg_legal_o),
    .log2_i     (cfg_log2_o),
    .idx_o      (hdr_idx),
    .hdr_wr_o   (hdr_wr),
    .latch_o    (hdr_latch),
    .sel_hdr_o  (hdr_emit),
    .in_ready_o (in_ready_o),
    .out_valid_o(out_valid_o),
    .cfg_valid_o(cfg_valid_o),
    .drop_o     (drop_act)
  );

  assign out_data_o = hdr_emit ? hdr_rd : in_data_i;
endmodule

// File: rtl/frame_hdr_parser_chk.sv
module frame_hdr_parser_chk #(
  parameter int SMP_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [SMP_W-1:0] out_data_o,
  input logic             cfg_valid_o,
  input logic             hdr_emit,
  input logic             drop_act
);
  assert_hdr_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_emit |-> !in_ready_o);

  assert_cfg_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |=> !cfg_valid_o);

  assert_cfg_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> (!in_ready_o && !out_valid_o));

  assert_drop_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_act |-> (!out_valid_o && in_ready_o));

  assert_hdr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_emit && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

bind frame_hdr_parser frame_hdr_parser_chk #(.SMP_W(SMP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_data_o (out_data_o),
  .cfg_valid_o(cfg_valid_o),
  .hdr_emit   (hdr_emit),
  .drop_act   (drop_act)
);

// File: tb/frame_hdr_parser_tb.sv
module frame_hdr_parser_tb;
  localparam int DW   = 16;
  localparam int SW   = 32;
  localparam int MINL = 4;
  localparam int MAXL = 6;
  localparam int HL   = 8;
  localparam int BUF  = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [SW-1:0] out_data;
  logic          cfg_valid;
  logic          cfg_fwd;
  logic [DW-1:0] cfg_log2;
  logic          cfg_legal;

  always #4 clk = ~clk;

  frame_hdr_parser #(.DATA_W(DW), .MIN_LOG2(MINL), .MAX_LOG2(MAXL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .cfg_valid_o(cfg_valid), .cfg_fwd_o(cfg_fwd), .cfg_log2_o(cfg_log2),
    .cfg_legal_o(cfg_legal)
  );

  logic [SW-1:0] stim [BUF];
  logic [SW-1:0] expv [BUF];
  bit            exp_hdr [BUF];
  int nstim, nexp, nfr;
  bit            f_fwd [64];
  logic [DW-1:0] f_log2 [64];
  bit            f_ok [64];
  int            f_eidx [64];
  int            f_iidx [64];
  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [SW-1:0] act, input logic [SW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic build();
    logic [DW-1:0] lens [8] = '{16'd0, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd15, 16'h0104};
    logic [DW-1:0] dirs [3] = '{16'd0, 16'd1, 16'd7};
    nstim = 0; nexp = 0; nfr = 0;
    for (int li = 0; li < 8; li++) begin
      for (int di = 0; di < 3; di++) begin
        logic [SW-1:0] h [HL];
        logic [DW-1:0] f;
        bit ok;
        int n;
        f  = DW'(nfr);
        ok = (lens[li] >= DW'(MINL)) && (lens[li] <= DW'(MAXL));
        h[0] = {dirs[di], 16'h1000 + f};
        h[1] = {lens[li], 16'h2000 + f};
        h[2] = {16'hBEEF, f};
        h[3] = {16'hA500 + f, 16'h3C00 + f};
        for (int k = 4; k < HL; k++) h[k] = {16'h7000 + DW'(k), f};
        f_fwd[nfr]  = (dirs[di] != 0);
        f_log2[nfr] = lens[li];
        f_ok[nfr]   = ok;
        for (int k = 0; k < HL; k++) begin
          stim[nstim++] = h[k];
          expv[nexp]    = (k == 3) ? {15'd0, ~ok, h[3][DW-1:0]} : h[k];
          exp_hdr[nexp] = 1'b1;
          nexp++;
        end
        f_eidx[nfr] = nexp;
        f_iidx[nfr] = nstim;
        n = ok ? (1 << lens[li]) : (1 << MAXL);
        for (int k = 0; k < n; k++) begin
          stim[nstim++] = {16'hD000 | f, DW'(k)};
          if (ok) begin
            expv[nexp]    = {16'hD000 | f, DW'(k)};
            exp_hdr[nexp] = 1'b0;
            nexp++;
          end
        end
        nfr++;
      end
    end
  endtask

  initial begin
    int ptr, eptr, fc, cyc, idle;
    bit pending, hold, prev_cfg;
    logic [SW-1:0] hold_data;
    build();
    ptr = 0; eptr = 0; fc = 0; cyc = 0; idle = 0;
    pending = 0; hold = 0; prev_cfg = 0; hold_data = '0;

    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready in reset", SW'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", SW'(out_valid), 0);
    chk(cfg_valid == 1'b0, "R1", "cfg_valid in reset", SW'(cfg_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    while (cyc < 100000) begin
      @(negedge clk);
      cyc++;
      in_valid  = pending ? 1'b1 : ((ptr < nstim) && (cyc % 5 != 3));
      in_data   = (ptr < nstim) ? stim[ptr] : '0;
      out_ready = (cyc % 7 != 2) && (cyc % 11 != 5);
      #1;
      if (hold)
        chk(out_valid && out_data == hold_data, "R9", "held output changed", out_data, hold_data);
      if (prev_cfg && cfg_valid)
        chk(1'b0, "R6", "strobe longer than one cycle", 2, 1);
      if (cfg_valid) begin
        if (fc >= nfr) chk(1'b0, "R6", "extra strobe", SW'(fc), SW'(nfr));
        else begin
          chk(!in_ready && !out_valid, "R6", "quiet strobe cycle", {in_ready, out_valid}, 0);
          chk(eptr == f_eidx[fc], "R6", "strobe output position", SW'(eptr), SW'(f_eidx[fc]));
          chk(ptr == f_iidx[fc], "R8", "strobe input position", SW'(ptr), SW'(f_iidx[fc]));
          chk(cfg_fwd == f_fwd[fc], "R3", "direction", SW'(cfg_fwd), SW'(f_fwd[fc]));
          chk(cfg_log2 == f_log2[fc], "R4", "log2 size", SW'(cfg_log2), SW'(f_log2[fc]));
          chk(cfg_legal == f_ok[fc], "R5", "legality", SW'(cfg_legal), SW'(f_ok[fc]));
          fc++;
        end
      end
      prev_cfg = cfg_valid;
      if (out_valid && eptr < nexp && exp_hdr[eptr])
        chk(!in_ready, "R2", "input open during header emit", SW'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (eptr >= nexp) chk(1'b0, "R8", "unexpected output", out_data, 0);
        else begin
          chk(out_data == expv[eptr], exp_hdr[eptr] ? "R5" : "R7",
              "output sample", out_data, expv[eptr]);
          eptr++;
        end
      end
      hold      = out_valid && !out_ready;
      hold_data = out_data;
      if (in_valid && in_ready) begin
        ptr++;
        pending = 1'b0;
      end else begin
        pending = in_valid;
      end
      if (ptr >= nstim && eptr >= nexp) idle++;
      if (idle > 20) break;
    end
    if (cyc >= 100000) chk(1'b0, "R2", "watchdog expired", SW'(cyc), 0);
    chk(ptr == nstim, "R2", "all input consumed", SW'(ptr), SW'(nstim));
    chk(eptr == nexp, "R7", "all output seen", SW'(eptr), SW'(nexp));
    chk(fc == nfr, "R6", "strobe count", SW'(fc), SW'(nfr));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule